// File: doc/BRIEF.md
# CAN Receive Buffer Acceptance Controller

This block sits behind a CAN protocol engine that has already decoded a frame and compared its identifier against a bank of acceptance filters. On a one-cycle completion strobe it takes the identifier, the identifier-type and remote-request flags, the length code, up to eight payload bytes, an error indication and the index of the filter that matched. It then decides which of two message buffers, if any, receives the frame.

Each buffer has a control byte and a read-only payload window on a byte-wide register port. Software programs a two-bit receive mode per buffer, reads the stored frame, then releases the buffer by writing its full flag to zero. Buffer 0 can be set to spill frames into buffer 1 while it is occupied. In that case buffer 1 records which low-numbered filter hit, so one handler can branch on the same field for both buffers.

A full buffer is never overwritten. A frame that finds its final destination occupied is dropped, and a sticky overflow flag records the loss. A one-cycle receive request marks every stored frame.

Top module: `can_rx_steer`

## Requirements
- R1: After synchronous reset both control bytes read 0x00, and `buf_full`, `buf_ovf` and `rx_irq` are all zero.
- R2: A buffer's mode field (control bits 6:5) selects frames: 00 takes error-free frames of either identifier type, 01 only error-free standard frames (`frm_ext`=0), 10 only error-free extended frames (`frm_ext`=1), and 11 every frame including those with `frm_err`=1. A rejected frame changes nothing.
- R3: Filter indices 0 and 1 steer a frame to buffer 0, indices 2 to 5 steer it to buffer 1, and indices 6 and 7 are ignored.
- R4: Storing a frame sets that buffer's full flag. The matching `rx_irq` bit is high for exactly the one cycle after the storing clock edge.
- R5: Writing control bit 7 as 0 clears the full flag, and writing it as 1 has no effect. While the flag is set the stored contents never change.
- R6: With the double-buffer enable (buffer 0 control bit 2) at 1, a frame accepted for buffer 0 while buffer 0 is full is stored in buffer 1. Buffer 1's mode is not consulted. With the enable at 0 no rollover occurs.
- R7: A frame whose final destination is full is dropped and sets that buffer's `buf_ovf` bit. The bit stays set until software clears the full flag of that buffer.
- R8: Buffer 0 control byte: bit 7 full, bits 6:5 mode, bit 4 reads 0, bit 3 stored frame was a remote request, bit 2 double-buffer enable, bit 1 read-only copy of bit 2, bit 0 filter index of the stored frame (0 or 1).
- R9: Buffer 1 control byte: bit 7 full, bits 6:5 mode, bit 4 reads 0, bit 3 remote request, bits 2:0 index of the filter that caused storage. After a rollover this index is 0 or 1.
- R10: Within a buffer window, offsets 1 to 4 read the identifier zero-extended to 32 bits with the least significant byte first. Offset 5 reads the length code in bits 3:0. Offsets 6 to 13 read payload bytes 0 to 7, where byte k is `frm_data[8k+7:8k]`. `reg_addr` bit 4 selects buffer 1.
- R11: Writes update only the mode, the full-flag clear and (buffer 0) the double-buffer enable. Writes to the remote-request, copy, filter-index and unused bits, and to any payload offset, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | Decoded frame available this cycle |
| frm_id | input | 29 | Frame identifier |
| frm_ext | input | 1 | Extended identifier frame |
| frm_rtr | input | 1 | Remote request frame |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Payload, byte k at bits 8k+7:8k |
| frm_err | input | 1 | Frame carried an error |
| frm_filt | input | 3 | Index of the matching acceptance filter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Bit 4 buffer select, bits 3:0 offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| buf_full | output | 2 | Full flag per buffer |
| buf_ovf | output | 2 | Sticky overflow per buffer |
| rx_irq | output | 2 | One-cycle store pulse per buffer |

## Verification
The bench builds the block with its default parameters: filters 0 and 1 feed buffer 0 and filters 2 to 5 feed buffer 1. This leaves indices 6 and 7 unassigned, so the ignore path can be exercised alongside every mode against standard, extended and errored frames. The same defaults make the rollover chain reachable in a few frames: buffer 0 full, then spill into buffer 1, then both full. That sequence drives the drop and overflow logic and the filter index that buffer 1 records after a spill.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

    localparam int unsigned CAN_ID_W      = 29;
    localparam int unsigned CAN_PAY_BYTES = 8;
    localparam int unsigned CAN_DLC_W     = 4;
    localparam int unsigned HIT_W         = 3;
    localparam int unsigned REG_OFF_W     = 4;

    localparam logic [REG_OFF_W-1:0] OFF_CTRL = 4'd0;
    localparam logic [REG_OFF_W-1:0] OFF_ID   = 4'd1;
    localparam logic [REG_OFF_W-1:0] OFF_DLC  = 4'd5;
    localparam logic [REG_OFF_W-1:0] OFF_DATA = 4'd6;

    typedef enum logic [1:0] {
        RXM_VALID = 2'b00,
        RXM_STD   = 2'b01,
        RXM_EXT   = 2'b10,
        RXM_ALL   = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic [CAN_ID_W-1:0]        id;
        logic                       ext;
        logic                       rtr;
        logic [CAN_DLC_W-1:0]       dlc;
        logic [8*CAN_PAY_BYTES-1:0] data;
    } can_frame_t;

    function automatic logic mode_accepts(rx_mode_e m, logic ext, logic err);
        logic ok;
        unique case (m)
            RXM_ALL:   ok = 1'b1;
            RXM_STD:   ok = !err && !ext;
            RXM_EXT:   ok = !err && ext;
            default:   ok = !err;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/can_rx_route.sv
module can_rx_route
    import can_rx_pkg::*;
#(
    parameter int unsigned NUM_FILT_B0 = 2,
    parameter int unsigned NUM_FILT    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_done,
    input  logic [HIT_W-1:0] frm_filt,
    input  logic             frm_ext,
    input  logic             frm_err,
    input  rx_mode_e         mode [2],
    input  logic [1:0]       full,
    input  logic             dben,
    output logic [1:0]       store,
    output logic [1:0]       ovf_set
);
    localparam logic [HIT_W-1:0] B0_LIM  = HIT_W'(NUM_FILT_B0);
    localparam logic [HIT_W-1:0] ALL_LIM = HIT_W'(NUM_FILT);

    logic tgt0, tgt1, acc0, acc1, roll, want1;

    always_comb begin
        tgt0    = frm_filt < B0_LIM;
        tgt1    = !tgt0 && (frm_filt < ALL_LIM);
        acc0    = frm_done && tgt0 && mode_accepts(mode[0], frm_ext, frm_err);
        acc1    = frm_done && tgt1 && mode_accepts(mode[1], frm_ext, frm_err);
        roll    = acc0 && full[0] && dben;
        want1   = acc1 || roll;
        store   = {want1 && !full[1], acc0 && !full[0]};
        ovf_set = {want1 && full[1], acc0 && full[0] && !dben};
    end

    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(store));

    // R2
    std_only_chk: assert property (@(posedge clk) disable iff (rst)
        (store[0] && mode[0] == RXM_STD) |-> !frm_ext);

    // R7
    drop_not_store_chk: assert property (@(posedge clk) disable iff (rst)
        (|ovf_set) |-> !(|store));

endmodule

// File: rtl/can_rx_msgbuf.sv
module can_rx_msgbuf
    import can_rx_pkg::*;
#(
    parameter bit IS_PRIMARY = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_en,
    input  can_frame_t           st_frm,
    input  logic [HIT_W-1:0]     st_hit,
    input  logic                 ovf_set,
    input  logic                 wr_en,
    input  logic [REG_OFF_W-1:0] wr_off,
    input  logic [7:0]           wr_data,
    input  logic [REG_OFF_W-1:0] rd_off,
    output logic [7:0]           rd_data,
    output logic                 full,
    output rx_mode_e             mode,
    output logic                 dben,
    output logic                 ovf,
    output logic                 irq
);
    localparam int unsigned PAY_IW = $clog2(CAN_PAY_BYTES);

    logic                       full_q, rtr_q, dben_q, ovf_q, irq_q;
    rx_mode_e                   mode_q;
    logic [HIT_W-1:0]           hit_q;
    logic [CAN_ID_W-1:0]        id_q;
    logic [CAN_DLC_W-1:0]       dlc_q;
    logic [8*CAN_PAY_BYTES-1:0] data_q;
    logic                       ctrl_wr;
    logic [31:0]                id32;
    logic [1:0]                 id_byte;
    logic [PAY_IW-1:0]          pay_byte;
    logic [7:0]                 ctrl_rd;
    logic                       unused_wbits;

    assign ctrl_wr      = wr_en && (wr_off == OFF_CTRL);
    assign unused_wbits = ^{wr_data[4:3], wr_data[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            rtr_q  <= 1'b0;
            dben_q <= 1'b0;
            ovf_q  <= 1'b0;
            irq_q  <= 1'b0;
            mode_q <= RXM_VALID;
            hit_q  <= '0;
            id_q   <= '0;
            dlc_q  <= '0;
            data_q <= '0;
        end else begin
            irq_q <= st_en;
            if (ctrl_wr) begin
                mode_q <= rx_mode_e'(wr_data[6:5]);
                dben_q <= IS_PRIMARY ? wr_data[2] : 1'b0;
                if (!wr_data[7]) begin
                    full_q <= 1'b0;
                    ovf_q  <= 1'b0;
                end
            end
            if (st_en) begin
                full_q <= 1'b1;
                rtr_q  <= st_frm.rtr;
                hit_q  <= st_hit;
                id_q   <= st_frm.id;
                dlc_q  <= st_frm.dlc;
                data_q <= st_frm.data;
            end
            if (ovf_set) ovf_q <= 1'b1;
        end
    end

    always_comb begin
        ctrl_rd  = IS_PRIMARY ? {full_q, mode_q, 1'b0, rtr_q, dben_q, dben_q, hit_q[0]}
                              : {full_q, mode_q, 1'b0, rtr_q, hit_q};
        id32     = {{(32-CAN_ID_W){1'b0}}, id_q};
        id_byte  = 2'(rd_off - OFF_ID);
        pay_byte = PAY_IW'(rd_off - OFF_DATA);
        if (rd_off == OFF_CTRL)
            rd_data = ctrl_rd;
        else if (rd_off < OFF_DLC)
            rd_data = id32[{id_byte, 3'b000} +: 8];
        else if (rd_off == OFF_DLC)
            rd_data = {{(8-CAN_DLC_W){1'b0}}, dlc_q};
        else if (rd_off < OFF_DATA + REG_OFF_W'(CAN_PAY_BYTES))
            rd_data = data_q[{pay_byte, 3'b000} +: 8];
        else
            rd_data = 8'h00;
    end

    assign full = full_q;
    assign mode = mode_q;
    assign dben = dben_q;
    assign ovf  = ovf_q;
    assign irq  = irq_q;

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full_q && !(ctrl_wr && !wr_data[7])) |=> full_q);

    // R5
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        full_q |-> !st_en);

    // R5
    payload_stable_chk: assert property (@(posedge clk) disable iff (rst)
        full_q |=> ($stable(id_q) && $stable(data_q) && $stable(dlc_q)));

    // R4
    irq_full_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> full_q);

endmodule

// File: rtl/can_rx_steer.sv
module can_rx_steer
    import can_rx_pkg::*;
#(
    parameter int unsigned NUM_FILT_B0 = 2,
    parameter int unsigned NUM_FILT    = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frm_done,
    input  logic [CAN_ID_W-1:0]        frm_id,
    input  logic                       frm_ext,
    input  logic                       frm_rtr,
    input  logic [CAN_DLC_W-1:0]       frm_dlc,
    input  logic [8*CAN_PAY_BYTES-1:0] frm_data,
    input  logic                       frm_err,
    input  logic [HIT_W-1:0]           frm_filt,
    input  logic                       reg_wr,
    input  logic [REG_OFF_W:0]         reg_addr,
    input  logic [7:0]                 reg_wdata,
    output logic [7:0]                 reg_rdata,
    output logic [1:0]                 buf_full,
    output logic [1:0]                 buf_ovf,
    output logic [1:0]                 rx_irq
);
    localparam int unsigned NBUF = 2;

    can_frame_t frame;
    rx_mode_e   mode_w [NBUF];
    logic [1:0] dben_w;
    logic [1:0] store_w, ovf_set_w;
    logic [7:0] rd_w [NBUF];
    logic       sel;

    assign frame = '{id: frm_id, ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc, data: frm_data};
    assign sel   = reg_addr[REG_OFF_W];

    can_rx_route #(
        .NUM_FILT_B0 (NUM_FILT_B0),
        .NUM_FILT    (NUM_FILT)
    ) route_i (
        .clk      (clk),
        .rst      (rst),
        .frm_done (frm_done),
        .frm_filt (frm_filt),
        .frm_ext  (frm_ext),
        .frm_err  (frm_err),
        .mode     (mode_w),
        .full     (buf_full),
        .dben     (dben_w[0]),
        .store    (store_w),
        .ovf_set  (ovf_set_w)
    );

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        can_rx_msgbuf #(
            .IS_PRIMARY (b == 0)
        ) buf_i (
            .clk     (clk),
            .rst     (rst),
            .st_en   (store_w[b]),
            .st_frm  (frame),
            .st_hit  (frm_filt),
            .ovf_set (ovf_set_w[b]),
            .wr_en   (reg_wr && (sel == 1'(b))),
            .wr_off  (reg_addr[REG_OFF_W-1:0]),
            .wr_data (reg_wdata),
            .rd_off  (reg_addr[REG_OFF_W-1:0]),
            .rd_data (rd_w[b]),
            .full    (buf_full[b]),
            .mode    (mode_w[b]),
            .dben    (dben_w[b]),
            .ovf     (buf_ovf[b]),
            .irq     (rx_irq[b])
        );
    end

    assign reg_rdata = sel ? rd_w[1] : rd_w[0];

    // R6
    no_dben_buf1_chk: assert property (@(posedge clk) disable iff (rst)
        !dben_w[1]);

endmodule

// File: tb/can_rx_steer_tb_top.sv
module can_rx_steer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        frm_done, frm_ext, frm_rtr, frm_err;
    logic [28:0] frm_id;
    logic [3:0]  frm_dlc;
    logic [63:0] frm_data;
    logic [2:0]  frm_filt;
    logic        reg_wr;
    logic [4:0]  reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [1:0]  buf_full, buf_ovf, rx_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_rx_steer dut_i (
        .clk(clk), .rst(rst), .frm_done(frm_done), .frm_id(frm_id),
        .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
        .frm_data(frm_data), .frm_err(frm_err), .frm_filt(frm_filt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .buf_full(buf_full), .buf_ovf(buf_ovf),
        .rx_irq(rx_irq)
    );

    // {mode[1:0], ext, err, filt[2:0], expected buf_full[1:0]}
    localparam logic [8:0] VEC [13] = '{
        9'b00_0_0_000_01, 9'b00_1_0_001_01, 9'b00_0_1_000_00,
        9'b01_0_0_000_01, 9'b01_1_0_000_00, 9'b10_1_0_011_10,
        9'b10_0_0_010_00, 9'b11_0_1_100_10, 9'b11_1_1_001_01,
        9'b00_0_0_101_10, 9'b00_0_0_110_00, 9'b11_1_0_111_00,
        9'b01_0_0_010_10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [2:0] f, input logic e, input logic er,
                        input logic [28:0] id, input logic r);
        @(negedge clk);
        frm_done = 1'b1; frm_filt = f; frm_ext = e; frm_err = er;
        frm_id = id; frm_rtr = r;
        @(negedge clk);
        frm_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; frm_done = 1'b0; frm_ext = 1'b0; frm_rtr = 1'b0; frm_err = 1'b0;
        frm_id = '0; frm_dlc = '0; frm_data = '0; frm_filt = '0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(5'h00, d); chk("R1 ctrl0", d, 8'h00);
        rd(5'h10, d); chk("R1 ctrl1", d, 8'h00);
        chk("R1 full", buf_full, 2'b00);
        chk("R1 ovf", buf_ovf, 2'b00);
        chk("R1 irq", rx_irq, 2'b00);

        // R2 / R3 mode and routing table
        foreach (VEC[i]) begin
            wr(5'h00, {1'b0, VEC[i][8:7], 5'b0});
            wr(5'h10, {1'b0, VEC[i][8:7], 5'b0});
            send(VEC[i][4:2], VEC[i][6], VEC[i][5], 29'h55, 1'b0);
            chk("R2 R3 full", buf_full, VEC[i][1:0]);
            chk("R4 irq", rx_irq, VEC[i][1:0]);
        end

        // R10 payload map, R8 control layout, R4 pulse width
        wr(5'h00, 8'h00);
        wr(5'h10, 8'h00);
        frm_dlc = 4'd5; frm_data = 64'h8877665544332211;
        send(3'd1, 1'b1, 1'b0, 29'h1ABCDEF5, 1'b1);
        chk("R4 irq set", rx_irq, 2'b01);
        chk("R4 full set", buf_full, 2'b01);
        @(negedge clk);
        chk("R4 irq one cycle", rx_irq, 2'b00);
        rd(5'h00, d); chk("R8 ctrl0", d, 8'h89);
        rd(5'h01, d); chk("R10 id0", d, 8'hF5);
        rd(5'h02, d); chk("R10 id1", d, 8'hDE);
        rd(5'h04, d); chk("R10 id3", d, 8'h1A);
        rd(5'h05, d); chk("R10 dlc", d, 8'h05);
        rd(5'h06, d); chk("R10 data0", d, 8'h11);
        rd(5'h0D, d); chk("R10 data7", d, 8'h88);

        // R5 full cannot be set/cleared by writing 1; R11 payload writes ignored
        wr(5'h00, 8'h80);
        wr(5'h01, 8'h00);
        chk("R5 full kept", buf_full, 2'b01);
        rd(5'h01, d); chk("R11 payload write ignored", d, 8'hF5);

        // R7 drop into full buffer without rollover; R5 contents unchanged
        frm_data = 64'hFFFF_FFFF_FFFF_FFFF;
        send(3'd0, 1'b0, 1'b0, 29'h0000_0077, 1'b0);
        chk("R7 ovf0", buf_ovf, 2'b01);
        chk("R7 irq none", rx_irq, 2'b00);
        rd(5'h01, d); chk("R5 id kept", d, 8'hF5);
        rd(5'h06, d); chk("R5 data kept", d, 8'h11);
        rd(5'h00, d); chk("R5 ctrl kept", d, 8'h89);

        // R7 clear with full flag
        wr(5'h00, 8'h00);
        chk("R7 ovf cleared", buf_ovf, 2'b00);
        chk("R5 full cleared", buf_full, 2'b00);

        // R11 read-only bits, R8 copy bit
        wr(5'h00, 8'h7F);
        rd(5'h00, d); chk("R11 R8 ctrl0 write", d, 8'h6F);

        // R6 rollover with dben=1; buffer 1 mode 01 not consulted
        wr(5'h10, 8'h20);
        send(3'd0, 1'b1, 1'b0, 29'h0000_0100, 1'b0);
        chk("R6 first to buf0", buf_full, 2'b01);
        send(3'd1, 1'b1, 1'b0, 29'h0000_0123, 1'b0);
        chk("R6 rollover full", buf_full, 2'b11);
        chk("R6 rollover irq", rx_irq, 2'b10);
        rd(5'h10, d); chk("R9 ctrl1 after rollover", d, 8'hA1);
        rd(5'h11, d); chk("R6 buf1 id", d, 8'h23);
        send(3'd0, 1'b0, 1'b0, 29'h0000_0001, 1'b0);
        chk("R7 ovf1 both full", buf_ovf, 2'b10);

        // R9 filter index recorded by buffer 1
        wr(5'h10, 8'h00);
        send(3'd4, 1'b0, 1'b0, 29'h0000_0044, 1'b1);
        rd(5'h10, d); chk("R9 ctrl1 filt4", d, 8'h8C);

        // R1 reset again clears everything
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R1 full after reset", buf_full, 2'b00);
        rd(5'h00, d); chk("R1 ctrl0 after reset", d, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule